// File: doc/BRIEF.md
# Wrapping cache-read address generator

This block generates the column address sequence for a cache read burst that wraps inside a fixed window. When a burst starts it captures a 12-bit starting column and a 2-bit wrap code. From then on, each byte strobe moves the column forward by one. When the column reaches the last byte of the selected window, it goes back to the first byte of that window. This continues until a stop input, which stands for chip-select going inactive, ends the burst.

Two of the windows (16 and 64 bytes) are powers of two, and a third (2048 bytes) is one as well. All three are aligned to their own length. The fourth window covers the whole 2112-byte page, so its end cannot be found by bit masking. For that reason the generator stores explicit base and last columns at the start of each burst. A start column outside the range the chosen code allows is replaced by column 0 and flagged for the rest of the burst.

Top module: `wrap_addr_gen`

## Requirements
- R1: The wrap code selects the window length: 2'b00 gives 2112 bytes, 2'b01 gives 2048 bytes, 2'b10 gives 64 bytes and 2'b11 gives 16 bytes.
- R2: With start_i high at a clock edge, col_o shows the captured start column and active_o is 1 after that edge.
- R3: For codes 2'b01, 2'b10 and 2'b11, the window is aligned to a multiple of its length and contains the start column.
- R4: For code 2'b00, the window spans columns 0 to 2111.
- R5: While active, a strobe moves col_o up by one inside the window. In a cycle without a strobe, col_o holds its value.
- R6: A strobe taken at the last column of the window sets col_o to the window's first column. wrap_o is high for exactly the one cycle after that strobe and is low at all other times.
- R7: A start column of 2048 or above with code 2'b01, or of 2112 or above with any other code, is replaced by column 0, and the window becomes the one that holds column 0. err_o is 1 for that burst. err_o is cleared by a valid start or by stop.
- R8: stop_i drops active_o after the next edge. While idle, strobes leave col_o unchanged and wrap_o low.
- R9: A start during an active burst reloads the code and the column. When start_i and stop_i are high in the same cycle, start_i wins.
- R10: After reset, col_o is 0 and active_o, wrap_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst and capture code_i and col_i |
| code_i | input | 2 | Wrap length code |
| col_i | input | 12 | Starting column |
| strobe_i | input | 1 | Advance one byte |
| stop_i | input | 1 | End the burst (chip-select inactive) |
| col_o | output | 12 | Current column |
| active_o | output | 1 | Burst in progress |
| wrap_o | output | 1 | One-cycle pulse after a wrap-back |
| err_o | output | 1 | Start column was out of range and was clamped |

## Verification
Every wrap code is tried with start columns swept across the whole page in steps of 31, plus the columns on each side of every window edge. These sweeps separate aligned windows from unaligned ones and valid starts from clamped ones. Some bursts use a strobe on every cycle and others a strobe on every other cycle, so holding on idle cycles is told apart from advancing. Full revolutions of the 2112-byte and 2048-byte windows show that the large wrap points sit at 2111 and 2047 and not at a masked boundary. Short scenarios then cover strobes while idle, a restart in the middle of a burst, and start and stop arriving together.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  typedef enum logic [1:0] {
    WRAP_PAGE  = 2'b00,
    WRAP_MAIN  = 2'b01,
    WRAP_MID   = 2'b10,
    WRAP_SMALL = 2'b11
  } wrap_code_e;
endpackage

// File: rtl/wrap_len_decode.sv
module wrap_len_decode #(
  parameter int COL_W     = 12,
  parameter int PAGE_LEN  = 2112,
  parameter int MAIN_LEN  = 2048,
  parameter int MID_LEN   = 64,
  parameter int SMALL_LEN = 16
) (
  input  wrap_pkg::wrap_code_e code_i,
  output logic [COL_W-1:0]     len_o,
  output logic                 aligned_o,
  output logic [COL_W-1:0]     limit_o
);
  always_comb begin
    unique case (code_i)
      wrap_pkg::WRAP_PAGE: len_o = COL_W'(PAGE_LEN);
      wrap_pkg::WRAP_MAIN: len_o = COL_W'(MAIN_LEN);
      wrap_pkg::WRAP_MID:  len_o = COL_W'(MID_LEN);
      default:             len_o = COL_W'(SMALL_LEN);
    endcase
    // full-page window is anchored at 0; others are length-aligned
    aligned_o = (code_i != wrap_pkg::WRAP_PAGE);
    limit_o   = (code_i == wrap_pkg::WRAP_MAIN) ? COL_W'(MAIN_LEN) : COL_W'(PAGE_LEN);
  end
endmodule

// File: rtl/wrap_window.sv
module wrap_window #(
  parameter int COL_W = 12
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] len_i,
  input  logic             aligned_i,
  input  logic [COL_W-1:0] limit_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] last_o,
  output logic [COL_W-1:0] first_o,
  output logic             err_o
);
  logic [COL_W-1:0] mask;

  always_comb begin
    mask    = len_i - COL_W'(1);
    err_o   = (col_i >= limit_i);
    first_o = err_o ? '0 : col_i;
    if (aligned_i) base_o = first_o & ~mask;
    else           base_o = '0;
    last_o  = base_o + mask;
  end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int COL_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] last_i,
  input  logic [COL_W-1:0] first_i,
  input  logic             err_i,
  input  logic             step_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             active_o,
  output logic             wrap_o,
  output logic             err_o
);
  logic [COL_W-1:0] base_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o    <= '0;
      base_q   <= '0;
      last_q   <= '0;
      active_o <= 1'b0;
      wrap_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      wrap_o <= 1'b0;
      if (load_i) begin
        col_o    <= first_i;
        base_q   <= base_i;
        last_q   <= last_i;
        err_o    <= err_i;
        active_o <= 1'b1;
      end else if (stop_i) begin
        active_o <= 1'b0;
        err_o    <= 1'b0;
      end else if (active_o && step_i) begin
        if (col_o == last_q) begin
          col_o  <= base_q;
          wrap_o <= 1'b1;
        end else begin
          col_o <= col_o + COL_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wrap_addr_gen.sv
module wrap_addr_gen #(
  parameter int COL_W     = 12,
  parameter int PAGE_LEN  = 2112,
  parameter int MAIN_LEN  = 2048,
  parameter int MID_LEN   = 64,
  parameter int SMALL_LEN = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       code_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             strobe_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             active_o,
  output logic             wrap_o,
  output logic             err_o
);
  logic [COL_W-1:0] len, limit, base, last, first;
  logic             aligned, err_start;

  wrap_len_decode #(
    .COL_W(COL_W), .PAGE_LEN(PAGE_LEN), .MAIN_LEN(MAIN_LEN),
    .MID_LEN(MID_LEN), .SMALL_LEN(SMALL_LEN)
  ) i_decode (
    .code_i   (wrap_pkg::wrap_code_e'(code_i)),
    .len_o    (len),
    .aligned_o(aligned),
    .limit_o  (limit)
  );

  wrap_window #(.COL_W(COL_W)) i_window (
    .col_i    (col_i),
    .len_i    (len),
    .aligned_i(aligned),
    .limit_i  (limit),
    .base_o   (base),
    .last_o   (last),
    .first_o  (first),
    .err_o    (err_start)
  );

  wrap_counter #(.COL_W(COL_W)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_i),
    .base_i  (base),
    .last_i  (last),
    .first_i (first),
    .err_i   (err_start),
    .step_i  (strobe_i),
    .stop_i  (stop_i),
    .col_o   (col_o),
    .active_o(active_o),
    .wrap_o  (wrap_o),
    .err_o   (err_o)
  );
endmodule

// File: rtl/wrap_addr_gen_chk.sv
module wrap_addr_gen_chk #(
  parameter int COL_W    = 12,
  parameter int PAGE_LEN = 2112
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             strobe_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             active_o,
  input logic             wrap_o,
  input logic             err_o
);
  a_r2_start_activates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> active_o);

  a_r5_step_or_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && strobe_i && !start_i && !stop_i) |=>
      (wrap_o || col_o == $past(col_o) + COL_W'(1)));

  a_r5_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !start_i) |=> ($stable(col_o) && !wrap_o));

  a_r6_wrap_goes_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && strobe_i && !start_i && !stop_i) ##1 wrap_o |-> col_o < $past(col_o));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);

  a_r7_err_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> active_o);

  a_r8_stop_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!active_o && !err_o));

  a_r8_idle_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !start_i) |=> ($stable(col_o) && !active_o && !wrap_o));

  a_r4_in_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> col_o < COL_W'(PAGE_LEN));
endmodule

bind wrap_addr_gen wrap_addr_gen_chk #(.COL_W(COL_W), .PAGE_LEN(PAGE_LEN)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .strobe_i(strobe_i),
  .stop_i(stop_i), .col_o(col_o), .active_o(active_o), .wrap_o(wrap_o), .err_o(err_o)
);

// File: tb/test_wrap_addr_gen.sv
`timescale 1ns/1ps
module test_wrap_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  code_i = '0;
  logic [11:0] col_i = '0;
  logic        strobe_i = 1'b0;
  logic        stop_i = 1'b0;
  logic [11:0] col_o;
  logic        active_o, wrap_o, err_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  wrap_addr_gen i_wrap_addr_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .code_i(code_i),
    .col_i(col_i), .strobe_i(strobe_i), .stop_i(stop_i), .col_o(col_o),
    .active_o(active_o), .wrap_o(wrap_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int win_len(input int code);
    case (code)
      0: return 2112;
      1: return 2048;
      2: return 64;
      default: return 16;
    endcase
  endfunction

  // reference window: base, last, first column, error
  task automatic model(input int code, input int col,
                       output int base, output int last, output int first, output bit err);
    int lim = (code == 1) ? 2048 : 2112;
    int len = win_len(code);
    err   = (col >= lim);
    first = err ? 0 : col;
    base  = (code == 0) ? 0 : (first / len) * len;
    last  = base + len - 1;
  endtask

  task automatic begin_burst(input int code, input int col, input bit with_stop);
    int b, l, f; bit e;
    model(code, col, b, l, f, e);
    @(negedge clk_i);
    start_i = 1'b1; code_i = 2'(code); col_i = 12'(col); stop_i = with_stop;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
    check(col_o == 12'(f), "R2 start column", col_o, f);
    check(active_o, "R2 active", active_o, 1);
    check(err_o == e, "R7 err flag", err_o, e);
  endtask

  // run n strobes; gap inserts an idle cycle between strobes
  task automatic run_burst(input int code, input int col, input int n, input bit gap);
    int b, l, f, cur; bit e;
    model(code, col, b, l, f, e);
    begin_burst(code, col, 1'b0);
    cur = f;
    for (int k = 0; k < n; k++) begin
      bit w;
      w = (cur == l);
      cur = w ? b : cur + 1;
      strobe_i = 1'b1;
      @(negedge clk_i);
      strobe_i = 1'b0;
      if (w) check(col_o == 12'(cur), "R6 wrap to base", col_o, cur);
      else check(col_o == 12'(cur), (code == 0) ? "R4 step" : "R3 step", col_o, cur);
      check(wrap_o == w, "R6 wrap pulse", wrap_o, w);
      if (gap) begin
        @(negedge clk_i);
        check(col_o == 12'(cur) && !wrap_o, "R5 hold", col_o, cur);
      end
    end
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    check(!active_o && !err_o, "R8 stop", active_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int edges[8] = '{15, 16, 63, 64, 2047, 2048, 2111, 2112};
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(col_o == 0 && !active_o && !wrap_o && !err_o, "R10 reset", col_o, 0);
    rst_ni = 1'b1;

    // R1 R3 R4 R7: sweep of codes and start columns
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s <= 2112; s += 31) run_burst(c, s, 40, s[0]);
      foreach (edges[i]) run_burst(c, edges[i], 20, 1'b0);
    end

    // R1 R4: full revolutions of the large windows
    run_burst(0, 2100, 2115, 1'b0);
    run_burst(1, 2040, 2052, 1'b0);
    run_burst(2, 130, 66, 1'b0);
    run_burst(3, 2100, 18, 1'b0);

    // R8: strobes while idle are ignored
    run_burst(3, 5, 3, 1'b0);
    for (int k = 0; k < 4; k++) begin
      strobe_i = 1'b1;
      @(negedge clk_i);
      check(col_o == 12'd8 && !wrap_o && !active_o, "R8 idle strobe", col_o, 8);
    end
    strobe_i = 1'b0;

    // R9: restart mid-burst reloads code and column
    begin_burst(2, 100, 1'b0);
    strobe_i = 1'b1; @(negedge clk_i); strobe_i = 1'b0;
    check(col_o == 12'd101, "R5 step", col_o, 101);
    begin_burst(3, 47, 1'b0);
    strobe_i = 1'b1; @(negedge clk_i); strobe_i = 1'b0;
    check(col_o == 12'd32 && wrap_o, "R9 reload wraps in new window", col_o, 32);
    // R9: start beats stop
    begin_burst(1, 2047, 1'b1);
    strobe_i = 1'b1; @(negedge clk_i); strobe_i = 1'b0;
    check(col_o == 12'd0 && wrap_o && active_o, "R9 start over stop", col_o, 0);
    // R7: error cleared by a valid start
    begin_burst(1, 2050, 1'b0);
    begin_burst(2, 10, 1'b0);
    check(!err_o, "R7 err cleared", err_o, 0);
    stop_i = 1'b1; @(negedge clk_i); stop_i = 1'b0;
    check(!active_o, "R8 stop", active_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule